// File: doc/BRIEF.md
# Four-Function Byte Operation Unit

This block is a small piece of purely combinational datapath. It takes two operands and a two-bit operation code, and drives one result of the same width as the operands. The code picks one of four functions: clear to zero, modular addition, bitwise exclusive-OR, or a test of whether both operands are odd.

The odd-operand test is not arithmetic. It yields zero only when the least significant bit of each operand is set. In every other case it yields one, with all upper result bits zero.

There is no clock, no storage, no carry-out and no overflow flag. The result follows the inputs within the same time step. Operand width is a parameter with a default of 8 bits.

Top module: `quad_op_unit`

## Requirements
- R1: With op_sel = 2'b00, res_out is all zeros whatever the operands.
- R2: With op_sel = 2'b01, res_out equals (a_in + b_in) modulo 2^DATA_W.
- R3: With op_sel = 2'b01, a carry out of the top bit is dropped: 8'hFF + 8'h01 gives 8'h00 and 8'h80 + 8'h80 gives 8'h00.
- R4: With op_sel = 2'b10, res_out equals a_in XOR b_in, bit by bit.
- R5: With op_sel = 2'b11, res_out is all zeros when bit 0 of a_in and bit 0 of b_in are both 1.
- R6: With op_sel = 2'b11 and at least one operand with bit 0 clear, res_out is 8'h01, so bits 7..1 are zero.
- R7: With op_sel = 2'b11, operand bits above bit 0 have no effect on res_out.
- R8: res_out depends only on the present inputs. It settles after an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation code: 00 clear, 01 add, 10 XOR, 11 odd-operand test |
| a_in | input | DATA_W | First operand |
| b_in | input | DATA_W | Second operand |
| res_out | output | DATA_W | Result of the selected operation |

## Verification
The assertions assume that op_sel, a_in and b_in carry known 0/1 values whenever they are evaluated, and they skip any evaluation in which an input is unknown. The bench meets this by driving every input from time zero. It changes inputs only on the falling clock edge, so each check reads a settled value. The add and XOR assertions check the result through the inverse operation, subtraction or XOR with b_in, rather than by recomputing it. Operands come from a fixed vector table and seeded random values, and each random operand is a fully defined byte.

// File: rtl/quad_op_pkg.sv
// Package: shared operation codes for the four-function operation unit.
// Assumes: the code width is fixed at two bits; the encoding is decoded by
// the top-level selector and relied on by the bench.
package quad_op_pkg;

    localparam int OP_CODE_W = 2;

    typedef enum logic [OP_CODE_W-1:0] {
        OP_CLEAR   = 2'b00,
        OP_ADD     = 2'b01,
        OP_XOR     = 2'b10,
        OP_ODDTEST = 2'b11
    } op_code_e;

endpackage

// File: rtl/quad_op_add.sv
// Module: wrap-around adder.
// Does: adds two operands and keeps only the low DATA_W bits of the sum.
// Assumes: no carry-in, no carry-out; the caller does not need overflow.
module quad_op_add #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] sum_o
);

    // Sum sized to the operand width, so the top carry drops out.
    always_comb begin
        sum_o = a_i + b_i;
    end

endmodule

// File: rtl/quad_op_xor.sv
// Module: bitwise exclusive-OR.
// Does: builds one XOR gate per bit position with a generate loop.
// Assumes: both operands have the same width.
module quad_op_xor #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] x_o
);

    // One gate for each bit position.
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign x_o[g] = a_i[g] ^ b_i[g];
    end

endmodule

// File: rtl/quad_op_oddtest.sv
// Module: odd-operand test.
// Does: drives 0 when both operands are odd, otherwise 1, zero-extended.
// Assumes: DATA_W is at least 2; only bit 0 of each operand is examined.
module quad_op_oddtest #(
    parameter int DATA_W = 8
) (
    input  logic              a_lsb_i,
    input  logic              b_lsb_i,
    output logic [DATA_W-1:0] flag_o
);

    localparam int PAD_W = DATA_W - 1;

    // Upper bits are zero; bit 0 is clear only when both operands are odd.
    always_comb begin
        flag_o = {{PAD_W{1'b0}}, ~(a_lsb_i & b_lsb_i)};
    end

endmodule

// File: rtl/quad_op_unit.sv
// Module: four-function operation unit (top).
// Does: selects one of clear, wrap-around add, XOR, or odd-operand test
// according to op_sel, fully combinationally.
// Assumes: inputs are stable, known values; there is no clock or reset.
module quad_op_unit #(
    parameter int DATA_W = 8
) (
    input  logic [1:0]        op_sel,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] res_out
);
    import quad_op_pkg::*;

    logic [DATA_W-1:0] sum_w;
    logic [DATA_W-1:0] xor_w;
    logic [DATA_W-1:0] odd_w;
    op_code_e          code_w;

    assign code_w = op_code_e'(op_sel);

    quad_op_add #(.DATA_W(DATA_W)) add_i (
        .a_i   (a_in),
        .b_i   (b_in),
        .sum_o (sum_w)
    );

    quad_op_xor #(.DATA_W(DATA_W)) xor_i (
        .a_i (a_in),
        .b_i (b_in),
        .x_o (xor_w)
    );

    quad_op_oddtest #(.DATA_W(DATA_W)) odd_i (
        .a_lsb_i (a_in[0]),
        .b_lsb_i (b_in[0]),
        .flag_o  (odd_w)
    );

    // Result selector; the default branch keeps the logic latch-free.
    always_comb begin
        case (code_w)
            OP_CLEAR:   res_out = '0;
            OP_ADD:     res_out = sum_w;
            OP_XOR:     res_out = xor_w;
            OP_ODDTEST: res_out = odd_w;
            default:    res_out = '0;
        endcase
    end

endmodule

// File: rtl/quad_op_unit_chk.sv
// Module: assertion checker for quad_op_unit, attached by bind.
// Does: checks each operation's result at the ports with immediate assertions.
// Assumes: evaluation is skipped while any input is unknown.
module quad_op_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic [1:0]        op_sel,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] res_out
);

    logic known_w;
    assign known_w = !$isunknown({op_sel, a_in, b_in});

    // Port-level checks of every operation code.
    always_comb begin
        if (known_w) begin
            if (op_sel == 2'b00)
                assert_clear_R1: assert (res_out == '0);
            if (op_sel == 2'b01)
                assert_sum_inverse_R2: assert (DATA_W'(res_out - b_in) == a_in);
            if (op_sel == 2'b10)
                assert_xor_inverse_R4: assert ((res_out ^ b_in) == a_in);
            if (op_sel == 2'b11 && a_in[0] && b_in[0])
                assert_both_odd_R5: assert (res_out == '0);
            if (op_sel == 2'b11 && !(a_in[0] && b_in[0]))
                assert_flag_one_R6: assert (res_out == DATA_W'(1));
        end
    end

endmodule

bind quad_op_unit quad_op_unit_chk #(.DATA_W(DATA_W)) chk_i (
    .op_sel  (op_sel),
    .a_in    (a_in),
    .b_in    (b_in),
    .res_out (res_out)
);

// File: tb/quad_op_unit_tb_top.sv
// Bench for quad_op_unit: a vector table walk, then directed and random tests.
module quad_op_unit_tb_top;

    localparam int W = 8;
    localparam int VEC_N = 12;

    // Each entry: {op_sel[1:0], a[7:0], b[7:0], expected[7:0]}
    localparam logic [25:0] VEC [VEC_N] = '{
        {2'b00, 8'hA5, 8'h3C, 8'h00},
        {2'b00, 8'hFF, 8'hFF, 8'h00},
        {2'b01, 8'h12, 8'h34, 8'h46},
        {2'b01, 8'hFF, 8'h01, 8'h00},
        {2'b01, 8'h80, 8'h80, 8'h00},
        {2'b01, 8'hF0, 8'h20, 8'h10},
        {2'b10, 8'hAA, 8'h55, 8'hFF},
        {2'b10, 8'hC3, 8'hC3, 8'h00},
        {2'b11, 8'h01, 8'h03, 8'h00},
        {2'b11, 8'h02, 8'h03, 8'h01},
        {2'b11, 8'h03, 8'h04, 8'h01},
        {2'b11, 8'h00, 8'h00, 8'h01}
    };

    logic         clk;
    logic [1:0]   op_sel;
    logic [W-1:0] a_in;
    logic [W-1:0] b_in;
    logic [W-1:0] res_out;

    int checks;
    int failures;
    int cyc;
    bit done;

    quad_op_unit #(.DATA_W(W)) dut_i (
        .op_sel  (op_sel),
        .a_in    (a_in),
        .b_in    (b_in),
        .res_out (res_out)
    );

    // 50 MHz clock.
    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 50000 && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Reference model written from the requirements.
    function automatic logic [W-1:0] model(input logic [1:0] s,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
        logic [W-1:0] r;
        case (s)
            2'b00:   r = '0;
            2'b01:   r = a + b;
            2'b10:   r = a ^ b;
            default: r = (a[0] && b[0]) ? 8'h00 : 8'h01;
        endcase
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] exp_v);
        checks = checks + 1;
        if (res_out !== exp_v) begin
            failures = failures + 1;
            $display("FAIL %s: sel=%b a=%h b=%h actual=%h expected=%h",
                     req, op_sel, a_in, b_in, res_out, exp_v);
        end
    endtask

    task automatic apply(input logic [1:0] s, input logic [W-1:0] a,
                         input logic [W-1:0] b);
        @(negedge clk);
        op_sel = s;
        a_in   = a;
        b_in   = b;
        #2;
    endtask

    function automatic string req_of(input logic [1:0] s);
        case (s)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R4";
            default: return "R5/R6";
        endcase
    endfunction

    initial begin
        checks = 0; failures = 0; cyc = 0; done = 0;
        op_sel = 2'b00; a_in = '0; b_in = '0;
        void'($urandom(32'd7));

        // Idle state with all inputs zero: result is zero (R1).
        apply(2'b00, 8'h00, 8'h00);
        check("R1", 8'h00);

        // Table walk (R1..R6; R3 carry-drop rows included).
        for (int i = 0; i < VEC_N; i++) begin
            apply(VEC[i][25:24], VEC[i][23:16], VEC[i][15:8]);
            check((VEC[i][25:24] == 2'b01 && VEC[i][7:0] < VEC[i][23:16]) ? "R3"
                  : req_of(VEC[i][25:24]), VEC[i][7:0]);
        end

        // R3: explicit carry-drop corners.
        apply(2'b01, 8'hFF, 8'hFF);
        check("R3", 8'hFE);

        // R7: upper bits ignored in the odd-operand test.
        apply(2'b11, 8'hFF, 8'hFD);
        check("R7", 8'h00);
        apply(2'b11, 8'hFE, 8'hFF);
        check("R7", 8'h01);
        apply(2'b11, 8'h80, 8'h7E);
        check("R7", 8'h01);

        // R8: result follows an input change with no clock edge between.
        apply(2'b10, 8'h0F, 8'h00);
        check("R8", 8'h0F);
        a_in = 8'hF0;
        #1;
        check("R8", 8'hF0);
        op_sel = 2'b01;
        #1;
        check("R8", 8'hF0);

        // Random sweep of every operation code.
        for (int n = 0; n < 200; n++) begin
            for (int s = 0; s < 4; s++) begin
                logic [W-1:0] ra;
                logic [W-1:0] rb;
                ra = W'($urandom);
                rb = W'($urandom);
                apply(2'(s), ra, rb);
                check(req_of(2'(s)), model(2'(s), ra, rb));
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule